// File: doc/BRIEF.md
# Partial Word Store Lane Unit

This unit converts a partial-word store request into one aligned 32-bit write toward a big-endian memory port. A request carries a byte address, a 32-bit register value and a mode bit. In begin mode the store covers the addressed byte and every byte after it up to the end of its word. In end mode the store covers the first byte of the word up to, but not including, the addressed byte. The unit computes the lane enables and masks the data so the memory side sees a single write with a byte-enable mask. A three-byte store is therefore never split into two writes.

One case writes nothing: end mode at offset zero. That request still leaves the unit as an output, but with a probe flag in place of the write flag. Downstream logic can then check write permission and mark the line dirty. The request and the result each sit in a one-entry pipeline stage with a valid/ready handshake. Each stage is run by a two-state machine: STAGE_EMPTY goes to STAGE_FULL on a load, STAGE_FULL goes back to STAGE_EMPTY on a drain with no new load, and STAGE_FULL stays in place on a drain with a load or on a stall.

Top module: `pstore_lane_unit`

## Requirements
- R1: The output address equals the request address with its two low bits forced to zero.
- R2: With mode 0 (begin), the enable mask covers the offset through byte 3 of the word. Enable bit 3 is address byte 0, the most significant lane, carrying data bits 31:24. The masks are 1111 for offset 0, 0111 for offset 1, 0011 for offset 2 and 0001 for offset 3.
- R3: With mode 1 (end) and a non-zero offset, the enable mask covers byte 0 up to the byte before the offset: 1000 for offset 1, 1100 for offset 2 and 1110 for offset 3.
- R4: With mode 1 and offset 0, the enable mask is 0000, the probe flag is 1 and the write flag is 0.
- R5: For each enable bit k that is set, output data bits 8k+7:8k equal the same bits of the request value. Every lane whose enable bit is clear carries zero.
- R6: Every request with a non-empty mask produces exactly one output, with the write flag 1 and the probe flag 0. This includes the three-byte masks 0111 and 1110.
- R7: The result appears on the output two clock edges after the request is accepted. Results leave in request order, one per cycle when the output is not stalled.
- R8: While out_valid is high and out_ready is low, the output stays valid and every output field stays unchanged. Once both stages hold an entry, req_ready is low.
- R9: After reset, out_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request stage can accept |
| req_addr | input | ADDR_W | Byte address of the store |
| req_end | input | 1 | 0 = begin mode, 1 = end mode |
| req_value | input | 32 | Register value to store |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Memory side accepts the result |
| out_addr | output | ADDR_W | Word-aligned address |
| out_be | output | 4 | Byte enables, bit 3 = address byte 0 |
| out_data | output | 32 | Lane-masked write data |
| out_write | output | 1 | Result is a real write |
| out_probe | output | 1 | Result is a protection probe only |

## Verification
The bench walks all eight mode and offset pairings. Getting the lane order reversed would mirror the masks, so begin offset 3 would enable byte 0 instead of byte 3. The end-mode zero-offset case is checked for an empty mask with the probe flag set. A design that treated it as a full-word write, or dropped it entirely, would fail there. The two three-byte masks are checked as single outputs, which catches a design that splits them into a byte write and a halfword write. A stall with both stages full checks that a leaky handshake does not lose or overwrite the held result, and that results come back in request order.

// File: rtl/psl_pkg.sv
package psl_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic {
        MODE_BEGIN = 1'b0,
        MODE_END   = 1'b1
    } store_mode_e;

    typedef enum logic {
        STAGE_EMPTY = 1'b0,
        STAGE_FULL  = 1'b1
    } stage_state_e;
endpackage

// File: rtl/psl_lane_map.sv
module psl_lane_map
    import psl_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int L_W     = LANE_W,
    localparam int O_W    = $clog2(N_LANES),
    localparam int D_W    = N_LANES * L_W
) (
    input  logic [O_W-1:0] offset,
    input  store_mode_e    mode,
    input  logic [D_W-1:0] value,
    output logic [N_LANES-1:0] be,
    output logic [D_W-1:0] data,
    output logic           write,
    output logic           probe
);
    // Lane k holds address byte (N_LANES-1-k): big-endian lane order.
    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        localparam int BYTE_POS = N_LANES - 1 - k;
        logic at_or_after;
        assign at_or_after = (BYTE_POS >= int'(offset));
        always_comb begin
            unique case (mode)
                MODE_BEGIN: be[k] = at_or_after;
                MODE_END:   be[k] = !at_or_after;
            endcase
        end
        assign data[k*L_W +: L_W] = be[k] ? value[k*L_W +: L_W] : '0;
    end

    assign probe = (mode == MODE_END) && (offset == '0);
    assign write = !probe;

    always_comb begin
        a_r4_probe_only_empty: assert (!probe || be == '0);
        a_r6_write_nonempty:   assert (!write || be != '0);
    end
endmodule

// File: rtl/psl_pipe_reg.sv
module psl_pipe_reg
    import psl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    stage_state_e state_q, state_d;
    logic         load;
    logic         drain;

    always_comb begin
        in_ready  = (state_q == STAGE_EMPTY) || out_ready;
        out_valid = (state_q == STAGE_FULL);
    end

    assign load  = in_valid && in_ready;
    assign drain = out_valid && out_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STAGE_EMPTY: if (load) state_d = STAGE_FULL;
            STAGE_FULL:  if (drain && !load) state_d = STAGE_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STAGE_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    out_data <= '0;
        else if (load) out_data <= in_data;
    end

    a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);
    a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data));
endmodule

// File: rtl/pstore_lane_unit.sv
module pstore_lane_unit
    import psl_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int REQ_W = ADDR_W + 1 + WORD_W,
    localparam int RES_W = ADDR_W + LANES + WORD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_end,
    input  logic [WORD_W-1:0] req_value,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LANES-1:0]  out_be,
    output logic [WORD_W-1:0] out_data,
    output logic              out_write,
    output logic              out_probe
);
    logic              held_valid, held_ready;
    logic [REQ_W-1:0]  held_req;
    logic [ADDR_W-1:0] held_addr;
    logic              held_end;
    logic [WORD_W-1:0] held_value;
    logic [LANES-1:0]  map_be;
    logic [WORD_W-1:0] map_data;
    logic              map_write, map_probe;
    logic [RES_W-1:0]  res_d, res_q;

    psl_pipe_reg #(.W(REQ_W)) u_req_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_ready (req_ready),
        .in_data  ({req_addr, req_end, req_value}),
        .out_valid(held_valid),
        .out_ready(held_ready),
        .out_data (held_req)
    );

    assign {held_addr, held_end, held_value} = held_req;

    psl_lane_map u_map (
        .offset(held_addr[OFF_W-1:0]),
        .mode  (store_mode_e'(held_end)),
        .value (held_value),
        .be    (map_be),
        .data  (map_data),
        .write (map_write),
        .probe (map_probe)
    );

    assign res_d = {held_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}},
                    map_be, map_data, map_write, map_probe};

    psl_pipe_reg #(.W(RES_W)) u_res_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (held_valid),
        .in_ready (held_ready),
        .in_data  (res_d),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (res_q)
    );

    assign {out_addr, out_be, out_data, out_write, out_probe} = res_q;

    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr[OFF_W-1:0] == '0));
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_write != out_probe));
    a_r8_full_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && held_valid) |-> !req_ready);
endmodule

// File: tb/test_pstore_lane_unit.sv
`timescale 1ns/1ps
module test_pstore_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_end;
    logic [31:0] req_addr, req_value;
    logic        out_valid, out_ready;
    logic [31:0] out_addr, out_data;
    logic [3:0]  out_be;
    logic        out_write, out_probe;

    int n_checks = 0;
    int n_fail   = 0;

    // {mode, offset[1:0], expected be[3:0], expected probe}
    localparam logic [7:0] VEC [8] = '{
        {1'b0, 2'd0, 4'b1111, 1'b0},
        {1'b0, 2'd1, 4'b0111, 1'b0},
        {1'b0, 2'd2, 4'b0011, 1'b0},
        {1'b0, 2'd3, 4'b0001, 1'b0},
        {1'b1, 2'd0, 4'b0000, 1'b1},
        {1'b1, 2'd1, 4'b1000, 1'b0},
        {1'b1, 2'd2, 4'b1100, 1'b0},
        {1'b1, 2'd3, 4'b1110, 1'b0}
    };

    always #2 clk = ~clk;

    pstore_lane_unit i_pstore_lane_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_end(req_end), .req_value(req_value),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_be(out_be), .out_data(out_data),
        .out_write(out_write), .out_probe(out_probe)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_data(input logic [31:0] v, input logic [3:0] be);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) if (be[k]) r[k*8 +: 8] = v[k*8 +: 8];
        return r;
    endfunction

    task automatic check_out(input logic [31:0] addr, input logic [31:0] v,
                             input logic [3:0] be, input bit probe);
        check(out_valid == 1'b1, "R7 valid", 64'(out_valid), 64'd1);
        check(out_addr == {addr[31:2], 2'b00}, "R1 addr", 64'(out_addr), 64'({addr[31:2], 2'b00}));
        check(out_be == be, "R2/R3 be", 64'(out_be), 64'(be));
        check(out_data == lane_data(v, be), "R5 data", 64'(out_data), 64'(lane_data(v, be)));
        check(out_probe == probe, "R4 probe", 64'(out_probe), 64'(probe));
        check(out_write == !probe, "R6 write", 64'(out_write), 64'(!probe));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] a0, a1, a2, v0, v1, v2;
        rst_n = 1'b0; req_valid = 1'b0; req_end = 1'b0;
        req_addr = '0; req_value = '0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid", 64'(out_valid), 64'd0);
        check(req_ready == 1'b1, "R9 req_ready", 64'(req_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk: every mode/offset pairing, latency checked.
        for (int i = 0; i < 8; i++) begin
            logic [31:0] a, v;
            a = 32'h4000_1000 + 32'(i * 16) + 32'(VEC[i][6:5]);
            v = 32'hA1B2_C3D4 ^ (32'h0101_0101 * 32'(i + 1));
            req_valid = 1'b1; req_end = VEC[i][7]; req_addr = a; req_value = v;
            @(negedge clk);
            req_valid = 1'b0;
            check(out_valid == 1'b0, "R7 latency early", 64'(out_valid), 64'd0);
            @(negedge clk);
            check_out(a, v, VEC[i][4:1], VEC[i][0]);
        end

        // R6: three-byte stores yield exactly one output.
        @(negedge clk);
        check(out_valid == 1'b0, "R6 single output", 64'(out_valid), 64'd0);

        // R8: stall with both stages full, then in-order drain (R7).
        a0 = 32'h0000_2001; v0 = 32'h1122_3344;
        a1 = 32'h0000_3003; v1 = 32'h5566_7788;
        a2 = 32'h0000_4000; v2 = 32'h99AA_BBCC;
        out_ready = 1'b0;
        req_valid = 1'b1; req_end = 1'b0; req_addr = a0; req_value = v0;
        @(negedge clk);
        req_end = 1'b1; req_addr = a1; req_value = v1;
        @(negedge clk);
        req_end = 1'b1; req_addr = a2; req_value = v2;
        check(req_ready == 1'b0, "R8 req_ready low when full", 64'(req_ready), 64'd0);
        repeat (3) @(negedge clk);
        check(req_ready == 1'b0, "R8 still full", 64'(req_ready), 64'd0);
        check_out(a0, v0, 4'b0111, 1'b0);
        out_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_out(a1, v1, 4'b1110, 1'b0);
        @(negedge clk);
        check_out(a2, v2, 4'b0000, 1'b1);
        @(negedge clk);
        check(out_valid == 1'b0, "R7 drained", 64'(out_valid), 64'd0);

        // R7: back-to-back throughput, one result per cycle.
        req_valid = 1'b1; req_end = 1'b0; req_addr = 32'h10; req_value = 32'hDEAD_BEEF;
        @(negedge clk);
        req_addr = 32'h22; req_value = 32'hCAFE_F00D;
        @(negedge clk);
        req_valid = 1'b0;
        check_out(32'h10, 32'hDEAD_BEEF, 4'b1111, 1'b0);
        @(negedge clk);
        check_out(32'h22, 32'hCAFE_F00D, 4'b0011, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule